// File: doc/BRIEF.md
# Sensor-Driven Adaptive Clock-Period Selector

This block picks the clock period for the execution stage of a SIMD pipeline. On each request it reads quantized sensor codes for process spread, device aging, temperature and supply voltage, together with a target timing-error class. It looks these up in a table held for each functional unit and returns a 5-bit period code. The code counts 0.2 ns steps, so code k means (k+1) x 0.2 ns, and 24 means 5.0 ns. A write port loads the tables before adaptation starts. An entry that has never been written reads as the slowest period, so an incomplete load errs toward safety.

Two selection modes exist. In fine mode every issued instruction names the unit it uses. The period comes from that unit's table, looked up with that unit's own sensor readings. In coarse mode one representative sensor set is shared by all units. The block looks up every unit's table with it and returns the largest period, which covers the slowest unit for a whole kernel.

Top module: `clk_period_sel`

## Requirements
- R1: After reset, `per_valid` is 0 and `per_code` is 24, and every table entry reads as unwritten.
- R2: A lookup that hits an entry never written since reset yields period code 24.
- R3: In fine mode (`mode`=0), the result is the entry of unit `req_fu` at the index built from that unit's sensor slot. The sensor slots of other units and the representative sensors have no effect.
- R4: In coarse mode (`mode`=1), every unit is looked up with the representative sensors, and the result is the largest of the looked-up codes.
- R5: Aging codes 5, 6 and 7 select the same entries as aging code 4.
- R6: A stored value above 24 is returned as 24, so `per_code` never exceeds 24.
- R7: `per_valid` is high in exactly the cycle after a cycle with `req_valid` high. When `req_valid` is low, `per_code` holds its value.
- R8: The table index is (((cls*4 + v>>1)*4 + t>>1)*5 + age)*4 + p. Here cls is `target_cls` (0 zero, 1 low, 2 medium, 3 high error class), v and t are the 3-bit voltage and temperature codes, age is the saturated aging level, and p is the 2-bit process code. Different classes reach different entries.
- R9: A write stored at one clock edge is seen by a lookup sampled at any later edge. A lookup sampled at the same edge as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_fu | input | FU_W | Unit whose table is written |
| cfg_addr | input | IDX_W | Table index to write (R8 layout) |
| cfg_data | input | 5 | Period code to store |
| mode | input | 1 | 0 fine (per instruction), 1 coarse (worst case over units) |
| target_cls | input | 2 | Target timing-error class |
| req_valid | input | 1 | Sample a lookup this cycle |
| req_fu | input | FU_W | Unit used by the instruction (fine mode) |
| fu_p_code | input | NUM_FU*2 | Per-unit process codes, unit g at bits [2g+1:2g] |
| fu_a_code | input | NUM_FU*3 | Per-unit aging codes |
| fu_t_code | input | NUM_FU*3 | Per-unit temperature codes |
| fu_v_code | input | NUM_FU*3 | Per-unit voltage codes |
| rep_p_code | input | 2 | Representative process code |
| rep_a_code | input | 3 | Representative aging code |
| rep_t_code | input | 3 | Representative temperature code |
| rep_v_code | input | 3 | Representative voltage code |
| per_valid | output | 1 | Result strobe |
| per_code | output | 5 | Selected period code |

## Verification
A lookup sampled at a rising edge is registered at that same edge. `per_valid` and `per_code` therefore carry the result for the whole next cycle. The bench drives each request on a falling edge and reads the result one full cycle later, on the next falling edge. A table write driven on a falling edge lands at the following rising edge, so the first lookup that can see it is the one driven after that edge. The bench checks the same-edge case by driving a write and a request together. After an idle cycle it checks that the strobe has dropped while the code stayed put.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int P_W    = 2;
  localparam int A_W    = 3;
  localparam int T_W    = 3;
  localparam int V_W    = 3;
  localparam int CLS_W  = 2;
  localparam int PER_W  = 5;
  localparam int A_LVLS = 5;
  localparam int P_LVLS = 1 << P_W;
  localparam int C_LVLS = 1 << CLS_W;

  typedef logic [PER_W-1:0] per_t;
  localparam per_t PER_MAX = per_t'(24);

  typedef enum logic {MODE_FINE = 1'b0, MODE_COARSE = 1'b1} mode_e;

  // aging beyond the last characterised level folds onto it
  function automatic logic [A_W-1:0] sat_age(input logic [A_W-1:0] a);
    return (a > A_W'(A_LVLS - 1)) ? A_W'(A_LVLS - 1) : a;
  endfunction

  function automatic per_t clamp_per(input per_t x);
    return (x > PER_MAX) ? PER_MAX : x;
  endfunction

  function automatic per_t per_max(input per_t a, input per_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cps_sensor_index.sv
module cps_sensor_index
  import cps_pkg::*;
#(
  parameter int T_IDX_W = 2,
  parameter int V_IDX_W = 2,
  parameter int IDX_W   = 11
) (
  input  logic [P_W-1:0]   p_code,
  input  logic [A_W-1:0]   a_code,
  input  logic [T_W-1:0]   t_code,
  input  logic [V_W-1:0]   v_code,
  input  logic [CLS_W-1:0] cls,
  output logic [IDX_W-1:0] idx
);
  localparam int T_LVLS = 1 << T_IDX_W;
  localparam int V_LVLS = 1 << V_IDX_W;

  logic [A_W-1:0]     a_lvl;
  logic [T_IDX_W-1:0] t_sel;
  logic [V_IDX_W-1:0] v_sel;
  int                 lin;

  assign a_lvl = sat_age(a_code);
  assign t_sel = t_code[T_W-1 -: T_IDX_W];
  assign v_sel = v_code[V_W-1 -: V_IDX_W];

  always_comb begin
    lin = int'(cls);
    lin = lin * V_LVLS + int'(v_sel);
    lin = lin * T_LVLS + int'(t_sel);
    lin = lin * A_LVLS + int'(a_lvl);
    lin = lin * P_LVLS + int'(p_code);
  end

  assign idx = IDX_W'(lin);
endmodule

// File: rtl/cps_fu_table.sv
module cps_fu_table
  import cps_pkg::*;
#(
  parameter int DEPTH = 1280,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  per_t             wdata,
  input  logic [IDX_W-1:0] raddr,
  output per_t             rcode
);
  per_t             mem [DEPTH];
  logic [DEPTH-1:0] written_q;
  logic             wr_hit;

  assign wr_hit = we && (waddr < IDX_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_hit) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) written_q <= '0;
    else if (wr_hit) written_q[waddr] <= 1'b1;
  end

  assign rcode = written_q[raddr] ? clamp_per(mem[raddr]) : PER_MAX;

  // R9
  write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_hit) && raddr == $past(waddr)) |-> rcode == clamp_per($past(wdata)));
endmodule

// File: rtl/clk_period_sel.sv
module clk_period_sel
  import cps_pkg::*;
#(
  parameter int NUM_FU  = 2,
  parameter int T_IDX_W = 2,
  parameter int V_IDX_W = 2,
  localparam int DEPTH  = P_LVLS * A_LVLS * (1 << T_IDX_W) * (1 << V_IDX_W) * C_LVLS,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [FU_W-1:0]       cfg_fu,
  input  logic [IDX_W-1:0]      cfg_addr,
  input  logic [PER_W-1:0]      cfg_data,
  input  logic                  mode,
  input  logic [CLS_W-1:0]      target_cls,
  input  logic                  req_valid,
  input  logic [FU_W-1:0]       req_fu,
  input  logic [NUM_FU*P_W-1:0] fu_p_code,
  input  logic [NUM_FU*A_W-1:0] fu_a_code,
  input  logic [NUM_FU*T_W-1:0] fu_t_code,
  input  logic [NUM_FU*V_W-1:0] fu_v_code,
  input  logic [P_W-1:0]        rep_p_code,
  input  logic [A_W-1:0]        rep_a_code,
  input  logic [T_W-1:0]        rep_t_code,
  input  logic [V_W-1:0]        rep_v_code,
  output logic                  per_valid,
  output logic [PER_W-1:0]      per_code
);
  mode_e sel_mode;
  assign sel_mode = mode_e'(mode);

  per_t rd_code [NUM_FU];

  for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
    logic [P_W-1:0]   s_p;
    logic [A_W-1:0]   s_a;
    logic [T_W-1:0]   s_t;
    logic [V_W-1:0]   s_v;
    logic [IDX_W-1:0] s_idx;
    logic             s_we;

    // coarse mode shares one sensor set; fine mode uses the unit's own slot
    assign s_p = (sel_mode == MODE_COARSE) ? rep_p_code : fu_p_code[g*P_W +: P_W];
    assign s_a = (sel_mode == MODE_COARSE) ? rep_a_code : fu_a_code[g*A_W +: A_W];
    assign s_t = (sel_mode == MODE_COARSE) ? rep_t_code : fu_t_code[g*T_W +: T_W];
    assign s_v = (sel_mode == MODE_COARSE) ? rep_v_code : fu_v_code[g*V_W +: V_W];
    assign s_we = cfg_we && (cfg_fu == FU_W'(g));

    cps_sensor_index #(.T_IDX_W(T_IDX_W), .V_IDX_W(V_IDX_W), .IDX_W(IDX_W)) idx_i (
      .p_code(s_p), .a_code(s_a), .t_code(s_t), .v_code(s_v),
      .cls(target_cls), .idx(s_idx)
    );

    cps_fu_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) tbl_i (
      .clk(clk), .rst_n(rst_n), .we(s_we), .waddr(cfg_addr), .wdata(cfg_data),
      .raddr(s_idx), .rcode(rd_code[g])
    );

    // R4
    coarse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && sel_mode == MODE_COARSE) |=> per_code >= $past(rd_code[g]));
  end

  per_t worst_code;
  per_t pick_code;
  per_t next_code;

  always_comb begin
    worst_code = '0;
    for (int i = 0; i < NUM_FU; i++) worst_code = per_max(worst_code, rd_code[i]);
  end

  assign pick_code = rd_code[req_fu];
  assign next_code = (sel_mode == MODE_COARSE) ? worst_code : pick_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_valid <= 1'b0;
      per_code  <= PER_MAX;
    end else begin
      per_valid <= req_valid;
      if (req_valid) per_code <= next_code;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> per_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !per_valid);
  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(per_code));
  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_code <= PER_MAX);
endmodule

// File: tb/clk_period_sel_tb.sv
module clk_period_sel_tb_top;
  localparam int IDX_W = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [0:0] cfg_fu = '0;
  logic [IDX_W-1:0] cfg_addr = '0;
  logic [4:0] cfg_data = '0;
  logic       mode = 1'b0;
  logic [1:0] target_cls = '0;
  logic       req_valid = 1'b0;
  logic [0:0] req_fu = '0;
  logic [3:0] fu_p_code = '0;
  logic [5:0] fu_a_code = '0, fu_t_code = '0, fu_v_code = '0;
  logic [1:0] rep_p_code = '0;
  logic [2:0] rep_a_code = '0, rep_t_code = '0, rep_v_code = '0;
  logic       per_valid;
  logic [4:0] per_code;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  clk_period_sel dut_i (
    .clk, .rst_n, .cfg_we, .cfg_fu, .cfg_addr, .cfg_data, .mode, .target_cls,
    .req_valid, .req_fu, .fu_p_code, .fu_a_code, .fu_t_code, .fu_v_code,
    .rep_p_code, .rep_a_code, .rep_t_code, .rep_v_code, .per_valid, .per_code
  );

  // index as written in R8, restated here
  function automatic int tb_idx(int cls, int p, int a, int t, int v);
    int age = (a > 4) ? 4 : a;
    return ((((cls * 4) + (v / 2)) * 4 + (t / 2)) * 5 + age) * 4 + p;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int fu, int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fu = 1'(fu); cfg_addr = IDX_W'(addr); cfg_data = 5'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // fields: mode fu cls | p0 a0 t0 v0 | p1 a1 t1 v1 | rp ra rt rv | expected
  localparam int NV = 15;
  localparam int VEC [NV][16] = '{
    '{0,0,0, 1,2,3,5, 3,6,6,1, 0,0,0,0,  7},
    '{0,1,0, 3,6,6,1, 1,2,3,5, 0,0,0,0, 12},
    '{0,0,1, 3,6,6,1, 0,0,0,0, 1,2,3,5, 24},
    '{0,1,1, 0,0,0,0, 3,4,6,1, 0,0,0,0,  3},
    '{0,1,1, 0,0,0,0, 3,7,6,1, 0,0,0,0,  3},
    '{0,1,0, 0,0,0,0, 2,1,2,2, 0,0,0,0,  4},
    '{0,0,0, 2,1,2,2, 0,0,0,0, 0,0,0,0, 24},
    '{0,0,3, 1,2,3,5, 0,0,0,0, 0,0,0,0,  2},
    '{1,0,0, 0,0,0,0, 0,0,0,0, 1,2,3,5, 12},
    '{1,1,3, 0,0,0,0, 0,0,0,0, 1,2,3,5,  9},
    '{1,0,1, 0,0,0,0, 0,0,0,0, 3,5,6,1, 24},
    '{1,0,2, 0,0,0,0, 0,0,0,0, 0,0,0,0, 24},
    '{1,0,0, 0,0,0,0, 0,0,0,0, 2,1,2,2, 24},
    '{1,1,0, 1,2,3,5, 1,2,3,5, 0,0,0,0, 20},
    '{0,1,0, 0,0,0,0, 0,0,0,0, 1,2,3,5,  6}
  };
  localparam string VTAG [NV] = '{
    "R3", "R3", "R6", "R5", "R5", "R3", "R2", "R8",
    "R4", "R4", "R4", "R2", "R4", "R4", "R3"
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(per_valid), 0);
    check("R1 code", int'(per_code), 24);
    rst_n = 1'b1;

    wr(0, tb_idx(0,1,2,3,5), 7);   wr(1, tb_idx(0,1,2,3,5), 12);
    wr(0, tb_idx(1,3,6,6,1), 30);  wr(1, tb_idx(1,3,6,6,1), 3);
    wr(0, tb_idx(2,0,0,0,0), 5);
    wr(0, tb_idx(3,1,2,3,5), 2);   wr(1, tb_idx(3,1,2,3,5), 9);
    wr(1, tb_idx(0,2,1,2,2), 4);
    wr(0, tb_idx(0,0,0,0,0), 20);  wr(1, tb_idx(0,0,0,0,0), 6);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i][0][0]; req_fu = 1'(VEC[i][1]); target_cls = 2'(VEC[i][2]);
      fu_p_code = {2'(VEC[i][7]),  2'(VEC[i][3])};
      fu_a_code = {3'(VEC[i][8]),  3'(VEC[i][4])};
      fu_t_code = {3'(VEC[i][9]),  3'(VEC[i][5])};
      fu_v_code = {3'(VEC[i][10]), 3'(VEC[i][6])};
      rep_p_code = 2'(VEC[i][11]); rep_a_code = 3'(VEC[i][12]);
      rep_t_code = 3'(VEC[i][13]); rep_v_code = 3'(VEC[i][14]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(VTAG[i], int'(per_code), VEC[i][15]);
      check("R7 strobe", int'(per_valid), 1);
    end

    // R7: idle cycle drops the strobe and holds the code (last result 6)
    @(negedge clk);
    check("R7 idle valid", int'(per_valid), 0);
    check("R7 hold code", int'(per_code), 6);

    // R9: write and lookup at the same edge see old data, later lookup sees new
    mode = 1'b0; req_fu = 1'b0; target_cls = 2'd0;
    fu_p_code = {2'd0, 2'd1}; fu_a_code = {3'd0, 3'd2};
    fu_t_code = {3'd0, 3'd3}; fu_v_code = {3'd0, 3'd5};
    cfg_we = 1'b1; cfg_fu = 1'b0; cfg_addr = IDX_W'(tb_idx(0,1,2,3,5)); cfg_data = 5'd15;
    req_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 same edge", int'(per_code), 7);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 later", int'(per_code), 15);

    // R1/R2: reset forgets every written entry
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 cleared table", int'(per_code), 24);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule